// File: doc/BRIEF.md
# Sleep Mode and Wake Controller

This block manages power for a small microcontroller. Software writes a control register that holds a sleep-enable bit and a 3-bit mode field. When the core then issues its sleep strobe, the controller latches the chosen mode and parks the core. It drops the per-domain clock enables and the oscillator enables that the mode does not need.

While the core is parked, the controller watches eight interrupt sources. It keeps only those that the latched mode allows. Two further rules apply: the external interrupt 0 must be level-sensed, and the display and timer 2 sources must be clocked asynchronously. The first accepted source starts the wake sequence. The core is held through an oscillator start-up count, in the modes that stopped the main oscillator, and then for four further cycles. After that the controller releases the core with a one-cycle "resume via interrupt" pulse.

A reset request that arrives while the core is parked releases it on the next cycle with a "resume via reset vector" pulse instead. The block touches no state outside its own registers.

Top module: `slp_wake_ctrl`

## Requirements
- R1: A sleep strobe while awake with the enable bit at 1 raises `sleeping` and `core_halt` from the next cycle; a strobe with the enable bit at 0 leaves `core_halt` low.
- R2: A write captures `cfg_wdata[0]` as the enable bit and `cfg_wdata[3:1]` as the mode (000 Idle, 001 ADC noise reduction, 010 Power-down, 011 Power-save, 110 Standby); a write alone changes no output.
- R3: In Idle, the CPU and flash clock enables are 0, the I/O, ADC and asynchronous clock enables are 1, the main oscillator enable is 1 and the timer oscillator enable equals `async_tmr`.
- R4: The mode codes 100, 101 and 111 behave exactly as Idle: same enables, same wake sources, no start-up count.
- R5: In ADC noise reduction, the enables are as in Idle except that the I/O clock enable is also 0.
- R6: In Power-down, all five clock enables and both oscillator enables are 0.
- R7: In Power-save, only the asynchronous clock enable is 1 and the timer oscillator enable equals `async_tmr`; the main oscillator enable is 0.
- R8: Standby (code 110) keeps only the main oscillator enable at 1 and uses no start-up count, but only when `xtal_src` is 1 at entry; otherwise the request is handled as Power-down.
- R9: The accepted wake sources are: all eight in Idle; all except general I/O in ADC noise reduction; ext0, pin change, serial start, display and timer 2 in Power-save; ext0, pin change and serial start in Power-down and Standby. Any other source leaves the core asleep.
- R10: Outside Idle, `irq_ext0` wakes only when `ext0_level` is 1; pin change has no such restriction.
- R11: In ADC noise reduction and Power-save, the display source wakes only with `async_disp` at 1 and timer 2 only with `async_tmr` at 1; Idle applies no such gate.
- R12: While awake or in the final halt, all clock enables and the main oscillator enable are 1. After an accepted wake, the core stays halted for `startup_cycles` cycles, in Power-down and Power-save only, and then for 4 cycles. `core_halt` then falls and `resume_irq` is high for exactly that one cycle.
- R13: A reset request while `core_halt` is high lowers `core_halt` on the next cycle with a one-cycle `resume_reset` pulse; while awake, the request has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset of the controller |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 4 | Write data: bit 0 enable, bits 3:1 mode |
| sleep_req | input | 1 | Sleep instruction strobe from the core |
| xtal_src | input | 1 | Crystal or resonator is the configured clock source |
| async_tmr | input | 1 | Timer 2 runs from its asynchronous clock |
| async_disp | input | 1 | Display controller runs from the asynchronous clock |
| startup_cycles | input | SU_W | Oscillator start-up count in cycles |
| ext0_level | input | 1 | External interrupt 0 configured for level sensing |
| irq_ext0 | input | 1 | External interrupt 0 request |
| irq_pinchg | input | 1 | Pin change request |
| irq_ser_start | input | 1 | Serial start-condition request |
| irq_disp | input | 1 | Display controller request |
| irq_tmr2 | input | 1 | Timer 2 request |
| irq_nvm_rdy | input | 1 | Non-volatile memory ready request |
| irq_adc | input | 1 | ADC conversion complete request |
| irq_io | input | 1 | Any other I/O request |
| sys_rst_req | input | 1 | System reset request |
| clken_cpu | output | 1 | CPU clock enable |
| clken_flash | output | 1 | Flash clock enable |
| clken_io | output | 1 | I/O clock enable |
| clken_adc | output | 1 | ADC clock enable |
| clken_async | output | 1 | Asynchronous domain clock enable |
| osc_main_en | output | 1 | Main oscillator enable |
| osc_tmr_en | output | 1 | Timer oscillator enable |
| sleeping | output | 1 | Core is asleep and waiting for a wake source |
| core_halt | output | 1 | Core is held (asleep, starting up or halted) |
| resume_irq | output | 1 | One-cycle pulse: resume through the interrupt |
| resume_reset | output | 1 | One-cycle pulse: restart from the reset vector |

## Verification
A wrongly latched or wrongly resolved mode shows up in the first cycle after the strobe as a wrong pattern on the seven enables. It shows up again at wake time, when a source that should be blocked wakes the core, or one that should wake it does not. A counter that loads or counts wrongly does not show up until the release, where the number of cycles with `core_halt` high differs from the start-up count plus four. A sequencer stuck in the wrong state shows up as a missing or doubled resume pulse, or as the wrong kind of resume after a reset request.

// File: rtl/slp_pkg.sv
`timescale 1ns/1ps
package slp_pkg;

  localparam int NUM_SRC = 8;

  // wake source bit positions inside the request vector
  localparam int SRC_EXT0 = 0;
  localparam int SRC_PCHG = 1;
  localparam int SRC_SER  = 2;
  localparam int SRC_DISP = 3;
  localparam int SRC_TMR  = 4;
  localparam int SRC_NVM  = 5;
  localparam int SRC_ADC  = 6;
  localparam int SRC_IO   = 7;

  typedef enum logic [2:0] {
    MODE_IDLE  = 3'b000,
    MODE_ADCNR = 3'b001,
    MODE_PDOWN = 3'b010,
    MODE_PSAVE = 3'b011,
    MODE_STBY  = 3'b110
  } slp_mode_e;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_START = 2'd2,
    ST_HALT  = 2'd3
  } slp_state_e;

  typedef struct packed {
    logic cpu;
    logic flash;
    logic io;
    logic adc;
    logic async_c;
    logic osc_main;
    logic osc_tmr;
  } clk_en_t;

  // map the raw register field to the mode that will really be used
  function automatic slp_mode_e resolve_mode(input logic [2:0] f, input logic xtal);
    slp_mode_e m;
    case (f)
      3'b000:  m = MODE_IDLE;
      3'b001:  m = MODE_ADCNR;
      3'b010:  m = MODE_PDOWN;
      3'b011:  m = MODE_PSAVE;
      3'b110:  m = xtal ? MODE_STBY : MODE_PDOWN;
      default: m = MODE_IDLE;
    endcase
    return m;
  endfunction

  // modes that stop the main oscillator need a start-up count on wake
  function automatic logic needs_startup(input slp_mode_e m);
    return (m == MODE_PDOWN) || (m == MODE_PSAVE);
  endfunction

  function automatic logic [NUM_SRC-1:0] wake_mask(input slp_mode_e m);
    logic [NUM_SRC-1:0] k;
    k = '0;
    k[SRC_EXT0] = 1'b1;
    k[SRC_PCHG] = 1'b1;
    k[SRC_SER]  = 1'b1;
    case (m)
      MODE_IDLE: k = '1;
      MODE_ADCNR: begin
        k[SRC_DISP] = 1'b1;
        k[SRC_TMR]  = 1'b1;
        k[SRC_NVM]  = 1'b1;
        k[SRC_ADC]  = 1'b1;
      end
      MODE_PSAVE: begin
        k[SRC_DISP] = 1'b1;
        k[SRC_TMR]  = 1'b1;
      end
      default: ;
    endcase
    return k;
  endfunction

  function automatic clk_en_t awake_clocks(input logic tmr_async);
    clk_en_t c;
    c = '1;
    c.osc_tmr = tmr_async;
    return c;
  endfunction

  function automatic clk_en_t sleep_clocks(input slp_mode_e m, input logic tmr_async);
    clk_en_t c;
    c = '0;
    case (m)
      MODE_ADCNR: begin
        c.adc      = 1'b1;
        c.async_c  = 1'b1;
        c.osc_main = 1'b1;
        c.osc_tmr  = tmr_async;
      end
      MODE_PDOWN: ;
      MODE_PSAVE: begin
        c.async_c = 1'b1;
        c.osc_tmr = tmr_async;
      end
      MODE_STBY: c.osc_main = 1'b1;
      default: begin
        c.io       = 1'b1;
        c.adc      = 1'b1;
        c.async_c  = 1'b1;
        c.osc_main = 1'b1;
        c.osc_tmr  = tmr_async;
      end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/slp_ctrl_reg.sv
`timescale 1ns/1ps
module slp_ctrl_reg #(
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [MODE_W:0]   cfg_wdata,
  output logic              sleep_en_q,
  output logic [MODE_W-1:0] mode_field_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_en_q   <= 1'b0;
      mode_field_q <= '0;
    end else if (cfg_we) begin
      sleep_en_q   <= cfg_wdata[0];
      mode_field_q <= cfg_wdata[MODE_W:1];
    end
  end

endmodule

// File: rtl/slp_wake_qual.sv
`timescale 1ns/1ps
module slp_wake_qual
  import slp_pkg::*;
(
  input  slp_mode_e          mode,
  input  logic [NUM_SRC-1:0] irq,
  input  logic               ext0_level,
  input  logic               async_tmr,
  input  logic               async_disp,
  output logic               wake_hit
);

  logic [NUM_SRC-1:0] mask;
  logic [NUM_SRC-1:0] src_ok;
  logic               async_gate;
  logic               deep;

  assign mask       = wake_mask(mode);
  assign async_gate = (mode == MODE_ADCNR) || (mode == MODE_PSAVE);
  assign deep       = (mode != MODE_IDLE);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (i == SRC_EXT0) begin : g_ext0
      assign src_ok[i] = irq[i] & mask[i] & (~deep | ext0_level);
    end else if (i == SRC_DISP) begin : g_disp
      assign src_ok[i] = irq[i] & mask[i] & (~async_gate | async_disp);
    end else if (i == SRC_TMR) begin : g_tmr
      assign src_ok[i] = irq[i] & mask[i] & (~async_gate | async_tmr);
    end else begin : g_plain
      assign src_ok[i] = irq[i] & mask[i];
    end
  end

  assign wake_hit = |src_ok;

endmodule

// File: rtl/slp_seq.sv
`timescale 1ns/1ps
module slp_seq
  import slp_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int HALT_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req,
  input  logic             sleep_en,
  input  logic [2:0]       mode_field,
  input  logic             xtal_src,
  input  logic [CNT_W-1:0] startup_cycles,
  input  logic             wake_hit,
  input  logic             sys_rst_req,
  output slp_state_e       st,
  output slp_mode_e        mode_q,
  output logic             resume_irq,
  output logic             resume_reset
);

  localparam logic [CNT_W-1:0] HALT_LOAD = CNT_W'(HALT_CYCLES);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic             go_startup;

  assign go_startup = needs_startup(mode_q) && (startup_cycles != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_RUN;
      mode_q       <= MODE_IDLE;
      cnt          <= '0;
      resume_irq   <= 1'b0;
      resume_reset <= 1'b0;
    end else begin
      resume_irq   <= 1'b0;
      resume_reset <= 1'b0;
      unique case (st)
        ST_RUN: begin
          if (sleep_req && sleep_en) begin
            st     <= ST_SLEEP;
            mode_q <= resolve_mode(mode_field, xtal_src);
          end
        end
        ST_SLEEP: begin
          if (sys_rst_req) begin
            st           <= ST_RUN;
            resume_reset <= 1'b1;
          end else if (wake_hit) begin
            if (go_startup) begin
              st  <= ST_START;
              cnt <= startup_cycles;
            end else begin
              st  <= ST_HALT;
              cnt <= HALT_LOAD;
            end
          end
        end
        ST_START: begin
          if (sys_rst_req) begin
            st           <= ST_RUN;
            resume_reset <= 1'b1;
          end else if (cnt == ONE) begin
            st  <= ST_HALT;
            cnt <= HALT_LOAD;
          end else begin
            cnt <= cnt - ONE;
          end
        end
        ST_HALT: begin
          if (sys_rst_req) begin
            st           <= ST_RUN;
            resume_reset <= 1'b1;
          end else if (cnt == ONE) begin
            st         <= ST_RUN;
            resume_irq <= 1'b1;
          end else begin
            cnt <= cnt - ONE;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/slp_clk_decode.sv
`timescale 1ns/1ps
module slp_clk_decode
  import slp_pkg::*;
(
  input  slp_state_e st,
  input  slp_mode_e  mode,
  input  logic       async_tmr,
  output clk_en_t    en
);

  always_comb begin
    unique case (st)
      ST_SLEEP: en = sleep_clocks(mode, async_tmr);
      ST_START: begin
        en          = sleep_clocks(mode, async_tmr);
        en.osc_main = 1'b1;
      end
      default:  en = awake_clocks(async_tmr);
    endcase
  end

endmodule

// File: rtl/slp_wake_ctrl.sv
`timescale 1ns/1ps
module slp_wake_ctrl
  import slp_pkg::*;
#(
  parameter int SU_W        = 8,
  parameter int HALT_CYCLES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [3:0]      cfg_wdata,
  input  logic            sleep_req,
  input  logic            xtal_src,
  input  logic            async_tmr,
  input  logic            async_disp,
  input  logic [SU_W-1:0] startup_cycles,
  input  logic            ext0_level,
  input  logic            irq_ext0,
  input  logic            irq_pinchg,
  input  logic            irq_ser_start,
  input  logic            irq_disp,
  input  logic            irq_tmr2,
  input  logic            irq_nvm_rdy,
  input  logic            irq_adc,
  input  logic            irq_io,
  input  logic            sys_rst_req,
  output logic            clken_cpu,
  output logic            clken_flash,
  output logic            clken_io,
  output logic            clken_adc,
  output logic            clken_async,
  output logic            osc_main_en,
  output logic            osc_tmr_en,
  output logic            sleeping,
  output logic            core_halt,
  output logic            resume_irq,
  output logic            resume_reset
);

  localparam int HALT_W = $clog2(HALT_CYCLES + 1);
  localparam int CNT_W  = (SU_W > HALT_W) ? SU_W : HALT_W;

  logic               sleep_en_q;
  logic [2:0]         mode_field_q;
  slp_mode_e          mode_q;
  slp_state_e         st;
  logic               wake_hit;
  logic [NUM_SRC-1:0] irq_vec;
  clk_en_t            en;

  assign irq_vec = {irq_io, irq_adc, irq_nvm_rdy, irq_tmr2,
                    irq_disp, irq_ser_start, irq_pinchg, irq_ext0};

  slp_ctrl_reg #(.MODE_W(3)) u_reg (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_wdata    (cfg_wdata),
    .sleep_en_q   (sleep_en_q),
    .mode_field_q (mode_field_q)
  );

  slp_wake_qual u_qual (
    .mode       (mode_q),
    .irq        (irq_vec),
    .ext0_level (ext0_level),
    .async_tmr  (async_tmr),
    .async_disp (async_disp),
    .wake_hit   (wake_hit)
  );

  slp_seq #(.CNT_W(CNT_W), .HALT_CYCLES(HALT_CYCLES)) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .sleep_req      (sleep_req),
    .sleep_en       (sleep_en_q),
    .mode_field     (mode_field_q),
    .xtal_src       (xtal_src),
    .startup_cycles (CNT_W'(startup_cycles)),
    .wake_hit       (wake_hit),
    .sys_rst_req    (sys_rst_req),
    .st             (st),
    .mode_q         (mode_q),
    .resume_irq     (resume_irq),
    .resume_reset   (resume_reset)
  );

  slp_clk_decode u_dec (
    .st        (st),
    .mode      (mode_q),
    .async_tmr (async_tmr),
    .en        (en)
  );

  assign clken_cpu   = en.cpu;
  assign clken_flash = en.flash;
  assign clken_io    = en.io;
  assign clken_adc   = en.adc;
  assign clken_async = en.async_c;
  assign osc_main_en = en.osc_main;
  assign osc_tmr_en  = en.osc_tmr;
  assign sleeping    = (st == ST_SLEEP);
  assign core_halt   = (st != ST_RUN);

endmodule

// File: rtl/slp_wake_ctrl_chk.sv
`timescale 1ns/1ps
module slp_wake_ctrl_chk
  import slp_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_req,
  input logic       sys_rst_req,
  input logic       sleep_en_q,
  input logic [2:0] mode_q,
  input logic       wake_hit,
  input logic       sleeping,
  input logic       core_halt,
  input logic       resume_irq,
  input logic       resume_reset,
  input logic       clken_cpu,
  input logic       clken_flash,
  input logic       clken_io,
  input logic       clken_adc,
  input logic       clken_async,
  input logic       osc_main_en,
  input logic       osc_tmr_en
);

  a_r1_strobe_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_halt && sleep_req && !sleep_en_q) |=> !core_halt);

  a_r1_strobe_enters: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_halt && sleep_req && sleep_en_q) |=> sleeping);

  a_r3_core_clocks_off: assert property (@(posedge clk) disable iff (!rst_n)
    sleeping |-> (!clken_cpu && !clken_flash));

  a_r6_pdown_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (sleeping && mode_q == MODE_PDOWN) |->
      !(clken_io || clken_adc || clken_async || osc_main_en || osc_tmr_en));

  a_r12_wake_leaves_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (sleeping && wake_hit && !sys_rst_req) |=> (core_halt && !sleeping));

  a_r12_awake_clocks: assert property (@(posedge clk) disable iff (!rst_n)
    !core_halt |-> (clken_cpu && clken_flash && clken_io && clken_adc &&
                    clken_async && osc_main_en));

  a_r12_release_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_halt) |-> (resume_irq || resume_reset));

  a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    resume_irq |=> !resume_irq);

  a_r12_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({resume_irq, resume_reset}));

  a_r13_reset_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (core_halt && sys_rst_req) |=> (!core_halt && resume_reset));

endmodule

bind slp_wake_ctrl slp_wake_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sleep_req    (sleep_req),
  .sys_rst_req  (sys_rst_req),
  .sleep_en_q   (sleep_en_q),
  .mode_q       (mode_q),
  .wake_hit     (wake_hit),
  .sleeping     (sleeping),
  .core_halt    (core_halt),
  .resume_irq   (resume_irq),
  .resume_reset (resume_reset),
  .clken_cpu    (clken_cpu),
  .clken_flash  (clken_flash),
  .clken_io     (clken_io),
  .clken_adc    (clken_adc),
  .clken_async  (clken_async),
  .osc_main_en  (osc_main_en),
  .osc_tmr_en   (osc_tmr_en)
);

// File: tb/slp_wake_ctrl_tb_top.sv
`timescale 1ns/1ps
module slp_wake_ctrl_tb_top;

  localparam int SU_W = 8;
  localparam int HALT = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst_n = 1'b0;
  logic            cfg_we = 1'b0;
  logic [3:0]      cfg_wdata = '0;
  logic            sleep_req = 1'b0;
  logic            xtal_src = 1'b0;
  logic            async_tmr = 1'b0;
  logic            async_disp = 1'b1;
  logic [SU_W-1:0] startup_cycles = '0;
  logic            ext0_level = 1'b0;
  logic [7:0]      src = '0;
  logic            sys_rst_req = 1'b0;

  logic clken_cpu, clken_flash, clken_io, clken_adc, clken_async;
  logic osc_main_en, osc_tmr_en, sleeping, core_halt, resume_irq, resume_reset;

  slp_wake_ctrl #(.SU_W(SU_W), .HALT_CYCLES(HALT)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .sleep_req(sleep_req), .xtal_src(xtal_src), .async_tmr(async_tmr),
    .async_disp(async_disp), .startup_cycles(startup_cycles),
    .ext0_level(ext0_level), .irq_ext0(src[0]), .irq_pinchg(src[1]),
    .irq_ser_start(src[2]), .irq_disp(src[3]), .irq_tmr2(src[4]),
    .irq_nvm_rdy(src[5]), .irq_adc(src[6]), .irq_io(src[7]),
    .sys_rst_req(sys_rst_req),
    .clken_cpu(clken_cpu), .clken_flash(clken_flash), .clken_io(clken_io),
    .clken_adc(clken_adc), .clken_async(clken_async),
    .osc_main_en(osc_main_en), .osc_tmr_en(osc_tmr_en),
    .sleeping(sleeping), .core_halt(core_halt),
    .resume_irq(resume_irq), .resume_reset(resume_reset)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    bit    is_rst;
    int    lat;
    string req;
  } exp_t;

  exp_t sb_q[$];
  bit   armed = 1'b0;
  int   lat_cnt = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [6:0] clk_vec();
    return {clken_cpu, clken_flash, clken_io, clken_adc, clken_async,
            osc_main_en, osc_tmr_en};
  endfunction

  // expected enables {cpu,flash,io,adc,async,main osc,timer osc} while asleep
  function automatic logic [6:0] exp_clk(logic [2:0] f, logic x, logic t);
    case (f)
      3'd1:    return {5'b00011, 1'b1, t};
      3'd2:    return 7'b0;
      3'd3:    return {5'b00001, 1'b0, t};
      3'd6:    return x ? 7'b0000010 : 7'b0;
      default: return {5'b00111, 1'b1, t};
    endcase
  endfunction

  function automatic int exp_lat(logic [2:0] f, logic x, int n);
    bit slow;
    slow = (f == 3'd2) || (f == 3'd3) || (f == 3'd6 && !x);
    return (slow ? n : 0) + HALT + 1;
  endfunction

  // monitor: counts halted cycles from the wake stimulus, compares on release
  always @(negedge clk) begin
    if (armed) begin
      if (core_halt) begin
        lat_cnt++;
      end else begin
        if (sb_q.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL R12 release with no expected item: actual 1 expected 0");
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(e.req, lat_cnt, e.lat, "halted cycles");
          chk(e.req, {resume_reset, resume_irq}, e.is_rst ? 2'b10 : 2'b01, "resume kind");
        end
        armed = 1'b0;
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic write_cfg(logic [2:0] f, logic en);
    cfg_we = 1'b1;
    cfg_wdata = {f, en};
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic launch(bit is_rst, int lat, string req, int idx);
    sb_q.push_back('{is_rst: is_rst, lat: lat, req: req});
    if (is_rst) sys_rst_req = 1'b1;
    else src[idx] = 1'b1;
    lat_cnt = 0;
    armed = 1'b1;
    while (armed) @(negedge clk);
    tick();
    src = '0;
    sys_rst_req = 1'b0;
  endtask

  task automatic enter(logic [2:0] f);
    write_cfg(f, 1'b1);
    sleep_req = 1'b1;
    tick();
    sleep_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_mode(logic [2:0] f, logic x, logic t, logic d, logic lvl, int n,
                          int blk, string blk_req, int wsrc, string clk_req, string lat_req);
    xtal_src = x;
    async_tmr = t;
    async_disp = d;
    ext0_level = lvl;
    startup_cycles = SU_W'(n);
    tick();
    enter(f);
    chk("R1", {sleeping, core_halt}, 2'b11, "asleep after strobe");
    chk(clk_req, clk_vec(), exp_clk(f, x, t), "sleep clock enables");
    if (blk >= 0) begin
      tick();
      src[blk] = 1'b1;
      repeat (3) tick();
      @(negedge clk);
      chk(blk_req, sleeping, 1'b1, "blocked source kept sleep");
      tick();
      src[blk] = 1'b0;
    end
    tick();
    launch(1'b0, exp_lat(f, x, n), lat_req, wsrc);
    @(negedge clk);
    chk("R12", {clk_vec(), resume_irq}, {6'h3F, t, 1'b0}, "awake enables after release");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R12", clk_vec(), 7'b1111110, "enables after reset");
    chk("R1", {sleeping, core_halt, resume_irq, resume_reset}, 4'b0, "status after reset");

    // R1: strobe with the enable bit clear does nothing
    tick();
    write_cfg(3'd2, 1'b0);
    sleep_req = 1'b1;
    tick();
    sleep_req = 1'b0;
    @(negedge clk);
    chk("R1", core_halt, 1'b0, "strobe with enable clear");
    tick();
    @(negedge clk);
    chk("R1", clk_vec(), 7'b1111110, "enables after ignored strobe");

    // R2: a register write alone changes nothing at the outputs
    tick();
    write_cfg(3'd2, 1'b1);
    @(negedge clk);
    chk("R2", {clk_vec(), core_halt}, {7'b1111110, 1'b0}, "write without strobe");

    run_mode(3'd0, 0, 0, 1, 0, 3, -1, "",    7, "R3", "R12");
    run_mode(3'd1, 0, 0, 1, 0, 3,  7, "R9",  6, "R5", "R12");
    run_mode(3'd1, 0, 0, 0, 0, 3,  3, "R11", 5, "R5", "R12");
    run_mode(3'd2, 0, 0, 1, 0, 3,  0, "R10", 1, "R6", "R12");
    run_mode(3'd2, 0, 0, 1, 1, 3,  6, "R9",  0, "R6", "R10");
    run_mode(3'd3, 0, 0, 1, 0, 2,  4, "R11", 2, "R7", "R12");
    run_mode(3'd3, 0, 1, 1, 0, 2,  5, "R9",  4, "R7", "R11");
    run_mode(3'd6, 0, 0, 1, 0, 2, -1, "",    1, "R8", "R8");
    run_mode(3'd6, 1, 0, 1, 0, 2,  3, "R9",  2, "R8", "R8");
    run_mode(3'd5, 0, 0, 1, 0, 2, -1, "",    7, "R4", "R4");
    run_mode(3'd7, 0, 1, 0, 0, 2, -1, "",    3, "R4", "R11");
    run_mode(3'd2, 0, 0, 1, 0, 0, -1, "",    2, "R6", "R12");

    // R13: reset request while asleep
    startup_cycles = SU_W'(10);
    tick();
    enter(3'd2);
    tick();
    launch(1'b1, 1, "R13", 0);

    // R13: reset request during the start-up count
    tick();
    enter(3'd2);
    tick();
    src[1] = 1'b1;
    tick();
    tick();
    @(negedge clk);
    chk("R13", {sleeping, core_halt}, 2'b01, "in start-up before reset");
    tick();
    launch(1'b1, 1, "R13", 0);

    // R13: reset request while awake has no effect
    tick();
    sys_rst_req = 1'b1;
    tick();
    @(negedge clk);
    chk("R13", {core_halt, resume_reset}, 2'b00, "reset request while awake");
    tick();
    @(negedge clk);
    chk("R13", {core_halt, resume_reset}, 2'b00, "reset request while awake, second cycle");
    sys_rst_req = 1'b0;

    tick();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule